// File: doc/BRIEF.md
# Conditional Multiply/Divide Step Unit

This block executes one arithmetic instruction per clock and decides, from a 9-bit digital-analog register (DAR) kept inside it, whether or how that instruction takes effect. Stepping loops can therefore multiply by shift-and-add and divide by non-restoring division. The multiplier or the quotient lives in the DAR. The caller supplies operands that are already shifted. On each valid instruction the unit takes a source operand, a destination operand, a 3-bit operation code and a 4-bit bit select. One cycle later it presents the new destination value, the carry and the DAR.

In a multiply, the multiplier is first loaded into the DAR. A conditional add is then issued once per multiplier bit, with the multiplicand shifted to that bit's weight. The add only takes effect when the selected DAR bit is 1. In a divide, a subtract of zero first sets the carry. A conditional subtract is then issued once per quotient bit, from bit 8 down to bit 0, with the divisor shifted to that weight. A held carry of 1 makes the step subtract and a carry of 0 makes it add back. Each step writes its new carry into the selected DAR bit, so the quotient builds up there.

Top module: `cstep_unit`

## Requirements
- R1: While reset is held, and right after it, res_o, dar_o, carry_o and res_valid_o are all zero.
- R2: op 1 (add) gives res_o = dst_i + src_i mod 2^25, and carry_o is the carry out of bit 24. op 2 (subtract) gives res_o = dst_i - src_i mod 2^25, and carry_o = 1 exactly when dst_i >= src_i as unsigned numbers.
- R3: op 3 (conditional add) performs the add of R2 when DAR bit sel_i is 1. When that bit is 0, res_o = dst_i and carry_o keeps its value.
- R4: op 4 (conditional subtract) subtracts when the held carry is 1 and adds when it is 0, with the carry rules of R2. The new carry is written into DAR bit sel_i and every other DAR bit stays as it was.
- R5: op 5 loads dar_o with src_i[24:16]. res_o = dst_i and carry_o holds.
- R6: op 6 gives res_o = {DAR, sixteen 1s}. dar_word_o always shows {dar_o, sixteen 1s}.
- R7: A sel_i of 9 to 15 reads as a 0 bit, so op 3 has no effect. op 4 still computes its result and carry but leaves the DAR unchanged.
- R8: While valid_i is low, res_o, dar_o and carry_o keep their values. res_valid_o is valid_i delayed by one cycle.
- R9: op 0 and op 7 are no-operations: res_o = dst_i, and carry_o and dar_o hold.
- R10: Nine conditional adds, driven as described above from a DAR holding multiplier m, leave the partial product equal to m times the multiplicand.
- R11: Nine conditional subtracts, driven as described above from a dividend N < 512*D, leave quotient N/D in dar_o. Adding D back to a negative final remainder yields N mod D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Operation code |
| sel_i | input | 4 | DAR bit select |
| src_i | input | 25 | Source operand |
| dst_i | input | 25 | Destination operand before the instruction |
| res_o | output | 25 | New destination value |
| res_valid_o | output | 1 | res_o belongs to an instruction accepted last cycle |
| dar_o | output | 9 | DAR contents |
| dar_word_o | output | 25 | DAR formatted as an operand word |
| carry_o | output | 1 | Held carry |

## Verification
A conditional subtract reads the held carry and also replaces it. In the same edge its new carry lands in one DAR bit. A following conditional add may select that same bit, or a conditional subtract may select a bit the multiply still needs. Random instruction mixes produce all of these back-to-back pairs with every select value, and a bench model tracks the carry and the DAR bit by bit. Every result, carry and DAR value is compared after each edge, and the complete multiply and divide sequences are checked against integer products and quotients.

// File: rtl/cstep_pkg.sv
package cstep_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_CADD = 3'd3,
    OP_CSUB = 3'd4,
    OP_WDAR = 3'd5,
    OP_RDAR = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  typedef struct packed {
    logic arith;     // an add or subtract takes effect
    logic sub;       // subtract rather than add
    logic bit_wr;    // new carry goes into the selected DAR bit
    logic dar_load;  // whole DAR loaded from source
    logic dar_read;  // destination takes formatted DAR
  } ctl_t;

endpackage

// File: rtl/cstep_decode.sv
module cstep_decode
  import cstep_pkg::*;
#(
  parameter int DAR_W = 9,
  parameter int SEL_W = 4
) (
  input  logic [2:0]       op,
  input  logic [SEL_W-1:0] sel,
  input  logic [DAR_W-1:0] dar,
  input  logic             carry,
  output ctl_t             ctl,
  output logic             cond_bit
);
  localparam int SPAN = 2 ** SEL_W;

  logic [SPAN-1:0] dar_pad;
  logic            sel_ok;

  assign dar_pad  = SPAN'(dar);
  assign cond_bit = dar_pad[sel];
  assign sel_ok   = (int'(sel) < DAR_W);

  always_comb begin
    ctl = '0;
    unique case (op_e'(op))
      OP_ADD:  ctl.arith = 1'b1;
      OP_SUB:  begin ctl.arith = 1'b1; ctl.sub = 1'b1; end
      OP_CADD: ctl.arith = cond_bit;
      OP_CSUB: begin
        ctl.arith  = 1'b1;
        ctl.sub    = carry;
        ctl.bit_wr = sel_ok;
      end
      OP_WDAR: ctl.dar_load = 1'b1;
      OP_RDAR: ctl.dar_read = 1'b1;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/cstep_alu.sv
module cstep_alu #(
  parameter int DATA_W = 25
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  function automatic logic [DATA_W:0] add_c(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b,
                                            input logic              cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  logic [DATA_W:0] wide;
  assign wide = add_c(dst, sub ? ~src : src, sub);
  assign sum  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];
endmodule

// File: rtl/cstep_dar.sv
module cstep_dar #(
  parameter int DAR_W = 9,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DAR_W-1:0] load_val,
  input  logic             bit_wr,
  input  logic [SEL_W-1:0] sel,
  input  logic             bit_val,
  output logic [DAR_W-1:0] dar_q
);
  for (genvar i = 0; i < DAR_W; i++) begin : g_bit
    logic hit;
    assign hit = bit_wr && (int'(sel) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dar_q[i] <= 1'b0;
      else if (load) dar_q[i] <= load_val[i];
      else if (hit)  dar_q[i] <= bit_val;
    end
  end
endmodule

// File: rtl/cstep_unit.sv
module cstep_unit
  import cstep_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int DAR_W  = 9,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic [DAR_W-1:0]  dar_o,
  output logic [DATA_W-1:0] dar_word_o,
  output logic              carry_o
);
  localparam int FILL_W = DATA_W - DAR_W;

  ctl_t              ctl;
  logic              cond_bit;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              exec_arith;   // named events for the checker
  logic              bit_wr_evt;
  logic              load_evt;
  logic [DATA_W-1:0] res_d;

  cstep_decode #(.DAR_W(DAR_W), .SEL_W(SEL_W)) u_dec (
    .op(op_i), .sel(sel_i), .dar(dar_o), .carry(carry_o),
    .ctl(ctl), .cond_bit(cond_bit)
  );

  cstep_alu #(.DATA_W(DATA_W)) u_alu (
    .dst(dst_i), .src(src_i), .sub(ctl.sub), .sum(sum), .cout(cout)
  );

  assign exec_arith = valid_i && ctl.arith;
  assign bit_wr_evt = valid_i && ctl.bit_wr;
  assign load_evt   = valid_i && ctl.dar_load;

  cstep_dar #(.DAR_W(DAR_W), .SEL_W(SEL_W)) u_dar (
    .clk(clk), .rst_n(rst_n),
    .load(load_evt), .load_val(src_i[DATA_W-1:FILL_W]),
    .bit_wr(bit_wr_evt), .sel(sel_i), .bit_val(cout),
    .dar_q(dar_o)
  );

  assign dar_word_o = {dar_o, {FILL_W{1'b1}}};

  always_comb begin
    if (ctl.arith)         res_d = sum;
    else if (ctl.dar_read) res_d = dar_word_o;
    else                   res_d = dst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o       <= '0;
      carry_o     <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i)    res_o   <= res_d;
      if (exec_arith) carry_o <= cout;
    end
  end
endmodule

// File: rtl/cstep_unit_chk.sv
module cstep_unit_chk #(
  parameter int DATA_W = 25,
  parameter int DAR_W  = 9,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic [DAR_W-1:0]  dar_o,
  input logic              carry_o,
  input logic              cond_bit
);
  localparam int FILL_W = DATA_W - DAR_W;

  assert_sub_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd2 |=> carry_o == ($past(dst_i) >= $past(src_i)));

  assert_cadd_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd3 && !cond_bit |=> res_o == $past(dst_i) && $stable(carry_o));

  assert_csub_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd4 && (int'(sel_i) < DAR_W) |=> dar_o[$past(sel_i)] == carry_o);

  assert_dar_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd5 |=> dar_o == $past(src_i[DATA_W-1:FILL_W]));

  assert_dar_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd6 |=> res_o == {$past(dar_o), {FILL_W{1'b1}}});

  assert_csub_oob_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd4 && (int'(sel_i) >= DAR_W) |=> $stable(dar_o));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(dar_o) && $stable(carry_o) && $stable(res_o) && !res_valid_o);

  assert_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == 3'd0 || op_i == 3'd7)
      |=> res_o == $past(dst_i) && $stable(carry_o) && $stable(dar_o));
endmodule

bind cstep_unit cstep_unit_chk #(.DATA_W(DATA_W), .DAR_W(DAR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .sel_i(sel_i),
  .src_i(src_i), .dst_i(dst_i), .res_o(res_o), .res_valid_o(res_valid_o),
  .dar_o(dar_o), .carry_o(carry_o), .cond_bit(cond_bit)
);

// File: tb/cstep_unit_test.sv
`timescale 1ns/1ps
module cstep_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  sel_i = '0;
  logic [24:0] src_i = '0;
  logic [24:0] dst_i = '0;
  logic [24:0] res_o;
  logic        res_valid_o;
  logic [8:0]  dar_o;
  logic [24:0] dar_word_o;
  logic        carry_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0]  dar_m = '0;
  logic        carry_m = 1'b0;
  logic [24:0] last_res = '0;

  always #4 clk = ~clk;

  cstep_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .sel_i(sel_i),
    .src_i(src_i), .dst_i(dst_i), .res_o(res_o), .res_valid_o(res_valid_o),
    .dar_o(dar_o), .dar_word_o(dar_word_o), .carry_o(carry_o)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Independent model: plain integer add / subtract / compare.
  task automatic step(input logic [2:0] op, input logic [3:0] sel,
                      input logic [24:0] src, input logic [24:0] dst, input string req);
    logic [24:0] er;
    logic        ec;
    logic [8:0]  ed;
    longint      s;
    er = dst; ec = carry_m; ed = dar_m;
    case (op)
      3'd1: begin s = longint'(dst) + longint'(src); er = s[24:0]; ec = s[25]; end
      3'd2: begin er = dst - src; ec = (dst >= src); end
      3'd3: if (sel < 9 && dar_m[sel]) begin
              s = longint'(dst) + longint'(src); er = s[24:0]; ec = s[25];
            end
      3'd4: begin
              if (carry_m) begin er = dst - src; ec = (dst >= src); end
              else begin s = longint'(dst) + longint'(src); er = s[24:0]; ec = s[25]; end
              if (sel < 9) ed[sel] = ec;
            end
      3'd5: ed = src[24:16];
      3'd6: er = {dar_m, 16'hFFFF};
      default: ;
    endcase
    valid_i = 1'b1; op_i = op; sel_i = sel; src_i = src; dst_i = dst;
    @(negedge clk);
    check(res_o == er, req, "result", res_o, er);
    check(carry_o == ec, req, "carry", carry_o, ec);
    check(dar_o == ed, req, "dar", dar_o, ed);
    check(res_valid_o == 1'b1, "R8", "res_valid", res_valid_o, 1);
    check(dar_word_o == {ed, 16'hFFFF}, "R6", "dar_word", dar_word_o, {ed, 16'hFFFF});
    dar_m = ed; carry_m = ec; last_res = er;
  endtask

  task automatic idle(input int cycles);
    logic [24:0] r0;
    r0 = res_o;
    valid_i = 1'b0; op_i = 3'd5; src_i = 25'h1ABCDEF; dst_i = 25'h0123456;
    repeat (cycles) @(negedge clk);
    check(res_valid_o == 1'b0, "R8", "idle res_valid", res_valid_o, 0);
    check(res_o == r0, "R8", "idle result", res_o, r0);
    check(dar_o == dar_m, "R8", "idle dar", dar_o, dar_m);
    check(carry_o == carry_m, "R8", "idle carry", carry_o, carry_m);
  endtask

  task automatic multiply(input logic [8:0] m, input logic [14:0] a);
    logic [24:0] p;
    step(3'd5, 4'd0, {m, 16'h0}, 25'd0, "R5");
    p = '0;
    for (int i = 0; i < 9; i++) begin
      step(3'd3, 4'(i), 25'(a) << i, p, "R3");
      p = last_res;
    end
    check(p == 25'(longint'(a) * longint'(m)), "R10", "product", p, longint'(a) * longint'(m));
  endtask

  task automatic divide(input int n, input int d);
    logic [24:0] r;
    logic [24:0] rem;
    step(3'd2, 4'd0, 25'd0, 25'(n), "R2");
    r = 25'(n);
    for (int k = 8; k >= 0; k--) begin
      step(3'd4, 4'(k), 25'(d) << k, r, "R4");
      r = last_res;
    end
    check(dar_o == 9'(n / d), "R11", "quotient", dar_o, n / d);
    rem = r[24] ? r + 25'(d) : r;
    check(rem == 25'(n % d), "R11", "remainder", rem, n % d);
  endtask

  initial begin
    void'($urandom(32'd2920));
    repeat (3) @(negedge clk);
    check(res_o == 0 && dar_o == 0 && carry_o == 0 && res_valid_o == 0,
          "R1", "reset state", {res_o, dar_o, carry_o, res_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid_o == 0 && dar_o == 0, "R1", "after reset", dar_o, 0);

    // R2 directed: carry boundaries
    step(3'd1, 4'd0, 25'h1FFFFFF, 25'd1, "R2");
    step(3'd2, 4'd0, 25'd5, 25'd5, "R2");
    step(3'd2, 4'd0, 25'd6, 25'd5, "R2");
    // R5 / R6 / R3
    step(3'd5, 4'd0, {9'b1_0100_0001, 16'h1234}, 25'd77, "R5");
    step(3'd6, 4'd0, 25'd0, 25'd3, "R6");
    step(3'd3, 4'd1, 25'd100, 25'd50, "R3");
    step(3'd3, 4'd0, 25'd100, 25'd50, "R3");
    // R7 out-of-range selects
    step(3'd3, 4'd12, 25'd9, 25'd1, "R7");
    step(3'd4, 4'd15, 25'd9, 25'd1, "R7");
    step(3'd4, 4'd9, 25'd1, 25'd3, "R7");
    // R9 no-operations
    step(3'd0, 4'd2, 25'd9, 25'h0ABCDE, "R9");
    step(3'd7, 4'd8, 25'd9, 25'h1000001, "R9");
    idle(3);

    multiply(9'h1FF, 15'h7FFF);
    multiply(9'd0, 15'd1234);
    divide(0, 7);
    divide(511 * 13 + 12, 13);
    divide(1, 1);
    for (int t = 0; t < 25; t++) begin
      multiply(9'($urandom), 15'($urandom));
      begin
        int d, n;
        d = 1 + int'($urandom % 16383);
        n = int'($urandom % (d * 512));
        divide(n, d);
      end
    end

    for (int t = 0; t < 400; t++) begin
      step(3'($urandom), 4'($urandom), 25'($urandom), 25'($urandom), "R4");
      if (t % 50 == 0) idle(1);
    end
    finish_run();
  end
endmodule